// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between a core's load/store path and its cache controller. It keeps every cache-line request that has gone out and not yet come back. Reads and writes live in two separate tables, each searched by line address. For every incoming request it decides in the same cycle whether the request goes out as a new miss, is turned back as conflicting with one already in flight, or rides along on a speculative load already waiting for the same line.

When a line comes back, the block replays, one per cycle, a response event for every request that was waiting on that line. The requests that joined the primary entry go first, in the order they arrived. The primary request goes last and closes the entry. Each event carries only the bytes the request asked for. A running count of live primary entries is kept at the port.

Top module: `orq_top`

## Requirements
- R1: After reset `outstanding` is 0, `ev_valid` is 0, `fill_ready` is 1, and `req_status` reads 3 (idle) while `req_valid` is low.
- R2: A request whose `req_kind[2]` is set (store 4, read-modify-write 5) is a write. A write to a line with no live write entry gets status 0 and `iss_valid`. Any write to a line that has a live write entry gets status 1 (aliased). Writes do not look at the read table.
- R3: A read-type request (load 0, speculative load 1, expose 2, validate 3) to a line with a live write entry gets status 1 and no issue.
- R4: A speculative load to a line whose live read entry is also a speculative load is merged. It gets status 0 with `req_merged` high and `iss_valid` low, and it is appended to that entry's dependent list.
- R5: Any other read-type request to a line with a live read entry gets status 1. This covers a speculative load meeting a load or expose entry, and a non-speculative read meeting any read entry.
- R6: A fill is accepted when `fill_valid` and `fill_ready` are both high, and `fill_write` selects the table. Starting the next cycle, one event per cycle is emitted: the dependents in arrival order, then the primary with `ev_last` set. `fill_ready` stays low until the burst ends.
- R7: Event data byte b (bits 8b+7:8b) is fill byte offset+b when b < size and offset+b < 8. Otherwise it is zero.
- R8: `ev_l1hit` is 1 only for a speculative-load event whose fill had `fill_external` low.
- R9: Expose, validate and store events return zero data. `iss_wdata` equals `req_wdata` only for an issued write and is zero for every issued read-type request.
- R10: `outstanding` rises by one per issued request and falls by one at each event with `ev_last`. Merges leave it unchanged.
- R11: A request that would need a new entry in a table already holding 8 live entries gets status 2 (busy) and no issue. A merge onto an entry already holding 3 dependents also gets status 2.
- R12: An accepted fill that matches no live entry in its selected table produces no event and leaves `outstanding` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_kind | input | 3 | Request kind code |
| req_line | input | 16 | Line address of the request |
| req_off | input | 3 | Byte offset inside the line |
| req_size | input | 3 | Bytes requested (1 to 4) |
| req_tag | input | 4 | Requester's identifier |
| req_wdata | input | 32 | Store data |
| req_status | output | 2 | 0 accepted, 1 aliased, 2 busy, 3 idle |
| req_merged | output | 1 | Accepted by merging onto a waiting speculative load |
| iss_valid | output | 1 | Request goes out as a new miss |
| iss_kind | output | 3 | Kind of the issued request |
| iss_line | output | 16 | Line of the issued request |
| iss_wdata | output | 32 | Data sent with the issue, zero for reads |
| fill_valid | input | 1 | Returned line present |
| fill_ready | output | 1 | Block can take a returned line |
| fill_write | input | 1 | Fill answers the write table |
| fill_line | input | 16 | Line address of the fill |
| fill_external | input | 1 | Data came from beyond the first-level cache |
| fill_data | input | 64 | Line bytes, byte i in bits 8i+7:8i |
| ev_valid | output | 1 | Response event present |
| ev_tag | output | 4 | Identifier of the request being answered |
| ev_data | output | 32 | Selected bytes |
| ev_l1hit | output | 1 | Speculative load served from the first-level cache |
| ev_last | output | 1 | Event closes the primary entry |
| outstanding | output | 5 | Live primary entries in both tables |

## Verification
The classification logic is driven with one table of requests applied in sequence to a growing set of live entries. The table pairs each kind of incoming request with each kind of entry already waiting: plain load against load, speculative against speculative, speculative against load or expose, any read against a write, and write against write. This separates the one merging case from the several aliasing cases, and it also shows that writes ignore the read table. Fills are then returned with dependents at different offsets and sizes, including one that runs past the end of the line, so the order and byte selection of each event can be told apart. Further fills cover external against local data, a line that matches nothing, a line in the wrong table, and a full table.

// File: rtl/orq_pkg.sv
package orq_pkg;
  parameter int LINE_W     = 16;
  parameter int TAG_W      = 4;
  parameter int LINE_BYTES = 8;
  parameter int RESP_BYTES = 4;
  parameter int ENTRIES    = 8;
  parameter int MAX_DEP    = 3;

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SZ_W   = $clog2(RESP_BYTES + 1);
  localparam int DEP_CW = $clog2(MAX_DEP + 1);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int CNT_W  = $clog2(2 * ENTRIES + 1);
  localparam int LD_W   = LINE_BYTES * 8;
  localparam int RD_W   = RESP_BYTES * 8;

  localparam logic [2:0] K_LOAD     = 3'd0;
  localparam logic [2:0] K_SPEC     = 3'd1;
  localparam logic [2:0] K_EXPOSE   = 3'd2;
  localparam logic [2:0] K_VALIDATE = 3'd3;
  localparam logic [2:0] K_STORE    = 3'd4;
  localparam logic [2:0] K_RMW      = 3'd5;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ALIAS = 2'd1,
    ST_BUSY  = 2'd2,
    ST_IDLE  = 2'd3
  } status_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [OFF_W-1:0] off;
    logic [SZ_W-1:0]  size;
  } slot_t;

  typedef struct packed {
    logic [LINE_W-1:0]         line;
    logic [2:0]                kind;
    slot_t                     prim;
    logic [DEP_CW-1:0]         ndeps;
    slot_t [MAX_DEP-1:0]       deps;
  } ent_t;

  function automatic logic is_write(input logic [2:0] k);
    return k[2];
  endfunction

  function automatic logic gives_data(input logic [2:0] k);
    return (k == K_LOAD) || (k == K_SPEC) || (k == K_RMW);
  endfunction

  // Bytes off..off+size-1 of the line, packed from bit 0, zero past the line end.
  function automatic logic [RD_W-1:0] pick_bytes(input logic [LD_W-1:0] d,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [SZ_W-1:0] size);
    logic [RD_W-1:0] r;
    int p;
    r = '0;
    for (int b = 0; b < RESP_BYTES; b++) begin
      p = int'(off) + b;
      if ((b < int'(size)) && (p < LINE_BYTES)) r[b*8 +: 8] = d[p*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/orq_table.sv
module orq_table
  import orq_pkg::*;
#(
  parameter bit DEP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  output logic [2:0]        look_kind,
  output logic              look_dep_full,
  output logic              full,
  input  logic              ins_en,
  input  ent_t              ins_ent,
  input  logic              dep_en,
  input  slot_t             dep_slot,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  output logic              fill_hit,
  output ent_t              fill_ent
);
  ent_t               ent [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] fmatch, rm, lmatch;
  logic [IDX_W-1:0]   free_idx;

  always_comb begin
    look_hit      = 1'b0;
    look_kind     = '0;
    look_dep_full = 1'b0;
    fill_ent      = '0;
    free_idx      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      fmatch[i] = vld[i] && (ent[i].line == fill_line);
      rm[i]     = fill_en && fmatch[i];
      lmatch[i] = vld[i] && !rm[i] && (ent[i].line == look_line);
      if (!vld[i]) free_idx = IDX_W'(i);
      if (lmatch[i]) begin
        look_hit      = 1'b1;
        look_kind     = ent[i].kind;
        look_dep_full = (int'(ent[i].ndeps) == MAX_DEP);
      end
      if (fmatch[i]) fill_ent = ent[i];
    end
    fill_hit = fill_en && (|fmatch);
    full     = &vld;
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic take;
    assign take = ins_en && (free_idx == IDX_W'(i)) && !vld[i];

    always_ff @(posedge clk) begin
      if (!rst_n)        vld[i] <= 1'b0;
      else if (rm[i])    vld[i] <= 1'b0;
      else if (take)     vld[i] <= 1'b1;
    end

    if (DEP_EN) begin : g_dep
      always_ff @(posedge clk) begin
        if (take) begin
          ent[i]       <= ins_ent;
          ent[i].ndeps <= '0;
        end else if (dep_en && lmatch[i]) begin
          ent[i].deps[ent[i].ndeps] <= dep_slot;
          ent[i].ndeps              <= ent[i].ndeps + 1'b1;
        end
      end
    end else begin : g_nodep
      always_ff @(posedge clk) begin
        if (take) begin
          ent[i]       <= ins_ent;
          ent[i].ndeps <= '0;
        end
      end
    end
  end

  // R11
  ins_only_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full);

  // R4
  dep_has_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dep_en |-> (look_hit && !look_dep_full));
endmodule

// File: rtl/orq_drain.sv
module orq_drain
  import orq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  ent_t             go_ent,
  input  logic [LD_W-1:0]  go_data,
  input  logic             go_ext,
  output logic             ready,
  output logic             ev_valid,
  output logic [TAG_W-1:0] ev_tag,
  output logic [RD_W-1:0]  ev_data,
  output logic             ev_l1hit,
  output logic             ev_last
);
  logic              busy;
  ent_t              cur;
  logic [LD_W-1:0]   data_q;
  logic              ext_q;
  logic [DEP_CW-1:0] idx;
  logic              on_dep;
  slot_t             sel;
  logic [2:0]        sel_kind;

  always_comb begin
    on_dep   = idx < cur.ndeps;
    sel      = on_dep ? cur.deps[idx] : cur.prim;
    sel_kind = on_dep ? K_SPEC : cur.kind;
    ready    = !busy;
    ev_valid = busy;
    ev_last  = busy && !on_dep;
    ev_tag   = sel.tag;
    ev_data  = gives_data(sel_kind) ? pick_bytes(data_q, sel.off, sel.size) : '0;
    ev_l1hit = busy && (sel_kind == K_SPEC) && !ext_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (ev_last) busy <= 1'b0;
      else         idx  <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      cur    <= go_ent;
      data_q <= go_data;
      ext_q  <= go_ext;
    end
  end

  // R6
  burst_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_last) |=> ev_valid);

  // R6
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
endmodule

// File: rtl/orq_top.sv
module orq_top
  import orq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [LINE_W-1:0] req_line,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [RD_W-1:0]   req_wdata,
  output logic [1:0]        req_status,
  output logic              req_merged,
  output logic              iss_valid,
  output logic [2:0]        iss_kind,
  output logic [LINE_W-1:0] iss_line,
  output logic [RD_W-1:0]   iss_wdata,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic              fill_write,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              fill_external,
  input  logic [LD_W-1:0]   fill_data,
  output logic              ev_valid,
  output logic [TAG_W-1:0]  ev_tag,
  output logic [RD_W-1:0]   ev_data,
  output logic              ev_l1hit,
  output logic              ev_last,
  output logic [CNT_W-1:0]  outstanding
);
  localparam int TOTAL = 2 * ENTRIES;

  logic       w_hit, w_full, w_dfull, w_fhit;
  logic [2:0] w_kind;
  ent_t       w_fent;
  logic       r_hit, r_full, r_dfull, r_fhit;
  logic [2:0] r_kind;
  ent_t       r_fent;

  logic       fill_acc, ins_w, ins_r, dep_r, closing;
  status_e    st;
  ent_t       new_ent;
  slot_t      req_slot;
  logic [CNT_W-1:0] cnt_q;

  assign fill_acc = fill_valid && fill_ready;
  assign req_slot = '{tag: req_tag, off: req_off, size: req_size};

  always_comb begin
    new_ent      = '0;
    new_ent.line = req_line;
    new_ent.kind = req_kind;
    new_ent.prim = req_slot;
  end

  orq_table #(.DEP_EN(1'b0)) u_wtab (
    .clk, .rst_n,
    .look_line(req_line), .look_hit(w_hit), .look_kind(w_kind),
    .look_dep_full(w_dfull), .full(w_full),
    .ins_en(ins_w), .ins_ent(new_ent),
    .dep_en(1'b0), .dep_slot(req_slot),
    .fill_en(fill_acc && fill_write), .fill_line(fill_line),
    .fill_hit(w_fhit), .fill_ent(w_fent)
  );

  orq_table #(.DEP_EN(1'b1)) u_rtab (
    .clk, .rst_n,
    .look_line(req_line), .look_hit(r_hit), .look_kind(r_kind),
    .look_dep_full(r_dfull), .full(r_full),
    .ins_en(ins_r), .ins_ent(new_ent),
    .dep_en(dep_r), .dep_slot(req_slot),
    .fill_en(fill_acc && !fill_write), .fill_line(fill_line),
    .fill_hit(r_fhit), .fill_ent(r_fent)
  );

  // Classification of the incoming request against both tables.
  always_comb begin
    st    = ST_IDLE;
    ins_w = 1'b0;
    ins_r = 1'b0;
    dep_r = 1'b0;
    if (req_valid) begin
      if (is_write(req_kind)) begin
        if (w_hit)       st = ST_ALIAS;
        else if (w_full) st = ST_BUSY;
        else begin st = ST_OK; ins_w = 1'b1; end
      end else if (w_hit) begin
        st = ST_ALIAS;
      end else if (r_hit) begin
        if ((req_kind == K_SPEC) && (r_kind == K_SPEC)) begin
          if (r_dfull) st = ST_BUSY;
          else begin st = ST_OK; dep_r = 1'b1; end
        end else begin
          st = ST_ALIAS;
        end
      end else if (r_full) begin
        st = ST_BUSY;
      end else begin
        st = ST_OK; ins_r = 1'b1;
      end
    end
  end

  assign req_status = st;
  assign req_merged = dep_r;
  assign iss_valid  = ins_w || ins_r;
  assign iss_kind   = req_kind;
  assign iss_line   = req_line;
  assign iss_wdata  = ins_w ? req_wdata : '0;

  orq_drain u_drain (
    .clk, .rst_n,
    .go(w_fhit || r_fhit),
    .go_ent(fill_write ? w_fent : r_fent),
    .go_data(fill_data), .go_ext(fill_external),
    .ready(fill_ready),
    .ev_valid, .ev_tag, .ev_data, .ev_l1hit, .ev_last
  );

  assign closing = ev_valid && ev_last;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + CNT_W'(iss_valid) - CNT_W'(closing);
  end
  assign outstanding = cnt_q;

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outstanding) <= TOTAL);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    closing |-> (outstanding != '0));
endmodule

// File: tb/sim_orq_top.sv
`timescale 1ns/1ps
module sim_orq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_line = '0;
  logic [2:0]  req_off = '0;
  logic [2:0]  req_size = '0;
  logic [3:0]  req_tag = '0;
  logic [31:0] req_wdata = 32'hDEADBEEF;
  logic [1:0]  req_status;
  logic        req_merged, iss_valid;
  logic [2:0]  iss_kind;
  logic [15:0] iss_line;
  logic [31:0] iss_wdata;
  logic        fill_valid = 1'b0, fill_write = 1'b0, fill_external = 1'b0;
  logic        fill_ready;
  logic [15:0] fill_line = '0;
  logic [63:0] fill_data = 64'hA7A6A5A4A3A2A1A0;
  logic        ev_valid, ev_l1hit, ev_last;
  logic [3:0]  ev_tag;
  logic [31:0] ev_data;
  logic [4:0]  outstanding;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  orq_top u0 (.*);

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] line;
    logic [3:0]  tag;
    logic [2:0]  off;
    logic [2:0]  size;
    logic [1:0]  st;
    logic        mg;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{3'd0, 16'h0010, 4'd1,  3'd0, 3'd4, 2'd0, 1'b0},  // R10 first load issues
    '{3'd0, 16'h0010, 4'd2,  3'd0, 3'd4, 2'd1, 1'b0},  // R5 load on load
    '{3'd1, 16'h0010, 4'd3,  3'd0, 3'd4, 2'd1, 1'b0},  // R5 spec on load
    '{3'd1, 16'h0020, 4'd4,  3'd0, 3'd4, 2'd0, 1'b0},  // R4 primary spec
    '{3'd1, 16'h0020, 4'd5,  3'd2, 3'd2, 2'd0, 1'b1},  // R4 merge
    '{3'd0, 16'h0020, 4'd6,  3'd0, 3'd4, 2'd1, 1'b0},  // R5 load on spec
    '{3'd4, 16'h0030, 4'd7,  3'd0, 3'd4, 2'd0, 1'b0},  // R2 store issues
    '{3'd5, 16'h0030, 4'd8,  3'd0, 3'd4, 2'd1, 1'b0},  // R2 rmw on store
    '{3'd0, 16'h0030, 4'd9,  3'd0, 3'd4, 2'd1, 1'b0},  // R3 load on write
    '{3'd1, 16'h0030, 4'd10, 3'd0, 3'd4, 2'd1, 1'b0},  // R3 spec on write
    '{3'd4, 16'h0010, 4'd11, 3'd0, 3'd4, 2'd0, 1'b0},  // R2 write ignores read table
    '{3'd2, 16'h0040, 4'd12, 3'd0, 3'd4, 2'd0, 1'b0},  // R9 expose issues
    '{3'd1, 16'h0040, 4'd13, 3'd0, 3'd4, 2'd1, 1'b0},  // R5 spec on expose
    '{3'd1, 16'h0020, 4'd14, 3'd6, 3'd4, 2'd0, 1'b1},  // R4 second merge
    '{3'd1, 16'h0020, 4'd15, 3'd1, 3'd1, 2'd0, 1'b1},  // R4 third merge
    '{3'd1, 16'h0020, 4'd0,  3'd0, 3'd4, 2'd2, 1'b0}   // R11 dependent list full
  };

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [15:0] l, input logic [3:0] t,
                      input logic [2:0] o, input logic [2:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_line = l; req_tag = t; req_off = o; req_size = s;
    #1;
  endtask

  task automatic idle_req();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_fill(input bit wr, input logic [15:0] l, input bit ext);
    @(negedge clk);
    fill_valid = 1'b1; fill_write = wr; fill_line = l; fill_external = ext;
    #1 check("R6 fill_ready before fill", fill_ready, 1);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_ev(input string rq, input logic [3:0] t, input logic [31:0] d,
                           input bit hit, input bit last);
    #1;
    check({rq, " ev_valid"}, ev_valid, 1);
    check({rq, " ev_tag"}, ev_tag, t);
    check({rq, " ev_data"}, ev_data, d);
    check({rq, " ev_l1hit"}, ev_l1hit, hit);
    check({rq, " ev_last"}, ev_last, last);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 outstanding", outstanding, 0);
    check("R1 ev_valid", ev_valid, 0);
    check("R1 fill_ready", fill_ready, 1);
    check("R1 idle status", req_status, 3);

    // Classification table, applied in order on a growing set of entries
    for (int i = 0; i < 16; i++) begin
      vec_t v;
      bit exp_iss;
      v = VEC[i];
      exp_iss = (v.st == 2'd0) && !v.mg;
      send(v.kind, v.line, v.tag, v.off, v.size);
      check($sformatf("R2/R3/R4/R5/R11 status vec %0d", i), req_status, v.st);
      check($sformatf("R4 merged vec %0d", i), req_merged, v.mg);
      check($sformatf("R4/R11 iss_valid vec %0d", i), iss_valid, exp_iss);
      if (exp_iss)
        check($sformatf("R9 iss_wdata vec %0d", i), iss_wdata,
              v.kind[2] ? 32'hDEADBEEF : 32'h0);
      idle_req();
    end
    #1 check("R10 count after table", outstanding, 5);

    // R6 R7 R8: spec primary with three dependents, local fill
    do_fill(1'b0, 16'h0020, 1'b0);
    #1 check("R6 fill_ready low in burst", fill_ready, 0);
    expect_ev("R6 R7 dep1", 4'd5,  32'h0000A3A2, 1'b1, 1'b0);
    expect_ev("R7 dep2 past line end", 4'd14, 32'h0000A7A6, 1'b1, 1'b0);
    expect_ev("R7 dep3", 4'd15, 32'h000000A1, 1'b1, 1'b0);
    expect_ev("R6 R8 primary", 4'd4, 32'hA3A2A1A0, 1'b1, 1'b1);
    #1 check("R6 burst ended", ev_valid, 0);
    check("R10 count after close", outstanding, 4);

    // R9 expose returns no data; R8 external fill
    do_fill(1'b0, 16'h0040, 1'b1);
    expect_ev("R9 expose", 4'd12, 32'h0, 1'b0, 1'b1);
    #1 check("R10 count", outstanding, 3);

    // R8 plain load from local fill is not flagged
    do_fill(1'b0, 16'h0010, 1'b0);
    expect_ev("R8 R7 load", 4'd1, 32'hA3A2A1A0, 1'b0, 1'b1);
    #1 check("R10 count", outstanding, 2);

    // R12 fill to unknown line, and fill of a write line via read table
    do_fill(1'b0, 16'h0099, 1'b0);
    #1 check("R12 miss no event", ev_valid, 0);
    check("R12 miss count", outstanding, 2);
    do_fill(1'b0, 16'h0030, 1'b0);
    #1 check("R12 wrong table no event", ev_valid, 0);
    check("R12 wrong table count", outstanding, 2);

    // R9 stores return zero data
    do_fill(1'b1, 16'h0030, 1'b1);
    expect_ev("R9 store", 4'd7, 32'h0, 1'b0, 1'b1);
    do_fill(1'b1, 16'h0010, 1'b0);
    expect_ev("R9 store2", 4'd11, 32'h0, 1'b0, 1'b1);
    #1 check("R10 count empty", outstanding, 0);

    // R11 read table fills to eight entries
    for (int i = 0; i < 8; i++) begin
      send(3'd0, 16'h0100 + 16'(i), 4'(i), 3'd0, 3'd4);
      check($sformatf("R11 fill slot %0d", i), req_status, 0);
      idle_req();
    end
    send(3'd0, 16'h0200, 4'd9, 3'd0, 3'd4);
    check("R11 full status", req_status, 2);
    check("R11 full no issue", iss_valid, 0);
    idle_req();
    #1 check("R11 R10 count at full", outstanding, 8);

    finish_run();
  end
endmodule